// File: doc/BRIEF.md
# Memory-Mapped Chip-Select Decoder

This block sits between a processor with a 16-bit address bus and an 8-bit data bus and the devices on that bus. It looks at the address and an active-low address-valid strobe and drives one active-low chip select for each of five devices: an 8 KB program ROM, a 4 KB variable RAM, a 4 KB serial-transfer RAM, a 512-byte I/O block and a four-register keypad. When an address is valid but no device claims it, a separate active-high `unmapped` flag is raised. The decoder is purely combinational.

A parameter chooses between two decoding modes. Full decoding compares every address bit above each device's own offset bits, so each device location answers at exactly one address. Partial decoding compares only the three top address bits, plus A12 for the RAM pair. This logic is cheaper, but devices appear again at many other addresses. A location in a device appears at 2^k addresses, where k is the number of address lines left out of that device's decode.

Top module: `mmap_cs_decoder`

## Requirements
- R1: With the strobe low, addresses 0x0000–0x1FFF drive `rom_sel_n` low in both modes. Every select is active low, so 0 means selected.
- R2: In full mode, with the strobe low, 0xC000–0xCFFF drives `var_ram_sel_n` low and 0xD000–0xDFFF drives `ser_ram_sel_n` low.
- R3: In full mode, with the strobe low, only 0x4000–0x41FF drives `io_sel_n` low.
- R4: In full mode, with the strobe low, only 0x9000–0x9003 drives `keypad_sel_n` low.
- R5: While `addr_valid_n` is high, all five selects are high and `unmapped` is low, whatever the address.
- R6: In full mode, with the strobe low, `unmapped` is 1 exactly for 0x2000–0x3FFF, 0x4200–0x8FFF, 0x9004–0xBFFF and 0xE000–0xFFFF.
- R7: At most one of the five selects and `unmapped` is active at any time. This holds for all 65536 addresses in both modes.
- R8: In partial mode, with the strobe low, every address in 0x4000–0x5FFF drives `io_sel_n` low. The I/O block therefore appears 16 times.
- R9: In partial mode, with the strobe low, every address in 0x8000–0x9FFF drives `keypad_sel_n` low. The keypad therefore appears 2048 times.
- R10: In partial mode, with the strobe low, 0xC000–0xFFFF selects the RAM pair. A12 = 0 picks `var_ram_sel_n` and A12 = 1 picks `ser_ram_sel_n`, so 0xE000 reaches the same location as 0xC000.
- R11: In partial mode, with the strobe low, `unmapped` is 1 exactly for 0x2000–0x3FFF, 0x6000–0x7FFF and 0xA000–0xBFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 16 | Processor address bus |
| addr_valid_n | input | 1 | Address-valid strobe, active low |
| rom_sel_n | output | 1 | Program ROM select, active low |
| var_ram_sel_n | output | 1 | Variable RAM select, active low |
| ser_ram_sel_n | output | 1 | Serial-transfer RAM select, active low |
| io_sel_n | output | 1 | I/O block select, active low |
| keypad_sel_n | output | 1 | Keypad select, active low |
| unmapped | output | 1 | Valid address that no device claims, active high |

## Verification
A table of addresses sits on each side of every region edge (first, last, one below, one above). These vectors show whether a decode compares too many bits or too few. The keypad's tail at 0x9004 and the I/O block's tail at 0x4200 matter most, because they separate full from partial matching. Alias addresses such as 0x5E00, 0x9FFC and 0xE000 separate the two modes. Repeating vectors with the strobe high shows that the strobe gates every output. A sweep over all 65536 addresses in both modes compares each output against a range-based model and shows at most one output active.

// File: rtl/mmap_cs_decoder.sv
module mmap_cs_decoder #(
  parameter bit FULL_DECODE = 1'b1
) (
  input  logic [15:0] addr,
  input  logic        addr_valid_n,
  output logic        rom_sel_n,
  output logic        var_ram_sel_n,
  output logic        ser_ram_sel_n,
  output logic        io_sel_n,
  output logic        keypad_sel_n,
  output logic        unmapped
);

  localparam int ROM_OFS_W = 13;
  localparam int RAM_OFS_W = 12;
  localparam int IO_OFS_W  = 9;
  localparam int KP_OFS_W  = 2;

  logic [2:0] top3;
  logic       valid;
  logic       hit_rom, hit_var, hit_ser, hit_io, hit_kp;
  logic       any_hit;

  assign top3  = addr[15:13];
  assign valid = ~addr_valid_n;

  assign hit_rom = (top3 == 3'b000);

  generate
    if (FULL_DECODE) begin : g_full
      assign hit_var = (addr[15:RAM_OFS_W] == 4'b1100);
      assign hit_ser = (addr[15:RAM_OFS_W] == 4'b1101);
      assign hit_io  = (addr[15:IO_OFS_W]  == 7'b0100000);
      assign hit_kp  = (addr[15:KP_OFS_W]  == 14'b1001_0000_0000_00);

      always_comb begin
        if (valid) begin
          p_io_range_r3: assert (!io_sel_n == (addr >= 16'h4000 && addr <= 16'h41FF));
          p_kp_range_r4: assert (!keypad_sel_n == (addr >= 16'h9000 && addr <= 16'h9003));
          p_ram_r2: assert ((!var_ram_sel_n == (addr >= 16'hC000 && addr <= 16'hCFFF)) &&
                            (!ser_ram_sel_n == (addr >= 16'hD000 && addr <= 16'hDFFF)));
          p_hole_r6: assert (unmapped == ((addr >= 16'h2000 && addr <= 16'h3FFF) ||
                                          (addr >= 16'h4200 && addr <= 16'h8FFF) ||
                                          (addr >= 16'h9004 && addr <= 16'hBFFF) ||
                                          (addr >= 16'hE000)));
        end
      end
    end else begin : g_partial
      assign hit_var = (top3[2:1] == 2'b11) && !addr[RAM_OFS_W];
      assign hit_ser = (top3[2:1] == 2'b11) &&  addr[RAM_OFS_W];
      assign hit_io  = (top3 == 3'b010);
      assign hit_kp  = (top3 == 3'b100);

      always_comb begin
        if (valid) begin
          p_io_alias_r8: assert (!io_sel_n == (addr >= 16'h4000 && addr <= 16'h5FFF));
          p_kp_alias_r9: assert (!keypad_sel_n == (addr >= 16'h8000 && addr <= 16'h9FFF));
          p_ram_alias_r10: assert ((!var_ram_sel_n || !ser_ram_sel_n) == (addr >= 16'hC000));
          p_hole_r11: assert (unmapped == ((addr >= 16'h2000 && addr <= 16'h3FFF) ||
                                           (addr >= 16'h6000 && addr <= 16'h7FFF) ||
                                           (addr >= 16'hA000 && addr <= 16'hBFFF)));
        end
      end
    end
  endgenerate

  assign any_hit = hit_rom | hit_var | hit_ser | hit_io | hit_kp;

  assign rom_sel_n     = ~(valid & hit_rom);
  assign var_ram_sel_n = ~(valid & hit_var);
  assign ser_ram_sel_n = ~(valid & hit_ser);
  assign io_sel_n      = ~(valid & hit_io);
  assign keypad_sel_n  = ~(valid & hit_kp);
  assign unmapped      = valid & ~any_hit;

  always_comb begin
    p_one_active_r7: assert ($onehot0({~rom_sel_n, ~var_ram_sel_n, ~ser_ram_sel_n,
                                       ~io_sel_n, ~keypad_sel_n, unmapped}));
    if (addr_valid_n)
      p_idle_when_invalid_r5: assert (rom_sel_n && var_ram_sel_n && ser_ram_sel_n &&
                                      io_sel_n && keypad_sel_n && !unmapped);
    if (valid)
      p_rom_range_r1: assert (!rom_sel_n == (addr <= 16'h1FFF));
  end

  if (ROM_OFS_W + 3 != 16) begin : g_bad_width
    initial $error("ROM offset width does not fit the 16-bit bus");
  end

endmodule

// File: tb/mmap_cs_decoder_tb.sv
module mmap_cs_decoder_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] addr;
  logic        vld_n;
  logic        f_rom, f_var, f_ser, f_io, f_kp, f_unm;
  logic        p_rom, p_var, p_ser, p_io, p_kp, p_unm;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  mmap_cs_decoder #(.FULL_DECODE(1'b1)) u_dut (
    .addr(addr), .addr_valid_n(vld_n),
    .rom_sel_n(f_rom), .var_ram_sel_n(f_var), .ser_ram_sel_n(f_ser),
    .io_sel_n(f_io), .keypad_sel_n(f_kp), .unmapped(f_unm));

  mmap_cs_decoder #(.FULL_DECODE(1'b0)) u_dut_partial (
    .addr(addr), .addr_valid_n(vld_n),
    .rom_sel_n(p_rom), .var_ram_sel_n(p_var), .ser_ram_sel_n(p_ser),
    .io_sel_n(p_io), .keypad_sel_n(p_kp), .unmapped(p_unm));

  // result vector {unmapped, keypad, io, ser, var, rom}, active high
  function automatic logic [5:0] model(input logic [15:0] a, input logic vn, input bit full);
    logic [5:0] r = '0;
    if (vn) return '0;
    if (a <= 16'h1FFF) r[0] = 1'b1;
    if (full) begin
      if (a >= 16'hC000 && a <= 16'hCFFF) r[1] = 1'b1;
      if (a >= 16'hD000 && a <= 16'hDFFF) r[2] = 1'b1;
      if (a >= 16'h4000 && a <= 16'h41FF) r[3] = 1'b1;
      if (a >= 16'h9000 && a <= 16'h9003) r[4] = 1'b1;
    end else begin
      if (a >= 16'hC000 && a[12] == 1'b0) r[1] = 1'b1;
      if (a >= 16'hC000 && a[12] == 1'b1) r[2] = 1'b1;
      if (a >= 16'h4000 && a <= 16'h5FFF) r[3] = 1'b1;
      if (a >= 16'h8000 && a <= 16'h9FFF) r[4] = 1'b1;
    end
    if (r == '0) r[5] = 1'b1;
    return r;
  endfunction

  function automatic logic [5:0] got(input bit full);
    if (full) return {f_unm, ~f_kp, ~f_io, ~f_ser, ~f_var, ~f_rom};
    return {p_unm, ~p_kp, ~p_io, ~p_ser, ~p_var, ~p_rom};
  endfunction

  task automatic check(input string req, input bit full, input logic [5:0] exp);
    n_cmp++;
    if (got(full) !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h vld_n=%b mode=%s got=%b exp=%b", req, addr, vld_n,
               full ? "full" : "partial", got(full), exp);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic vn);
    @(negedge clk);
    addr  = a;
    vld_n = vn;
    #1;
  endtask

  // {addr, expected full-mode result}
  localparam int NV = 16;
  localparam logic [21:0] VEC [NV] = '{
    {16'h0000, 6'b000001}, {16'h1FFF, 6'b000001}, {16'h2000, 6'b100000},
    {16'h3FFF, 6'b100000}, {16'h4000, 6'b001000}, {16'h41FF, 6'b001000},
    {16'h4200, 6'b100000}, {16'h8FFF, 6'b100000}, {16'h9000, 6'b010000},
    {16'h9003, 6'b010000}, {16'h9004, 6'b100000}, {16'hBFFF, 6'b100000},
    {16'hC000, 6'b000010}, {16'hCFFF, 6'b000010}, {16'hD000, 6'b000100},
    {16'hE000, 6'b100000}
  };

  initial begin
    addr = 16'h0000;
    vld_n = 1'b1;

    // idle state, strobe high (R5)
    apply(16'h0000, 1'b1);
    check("R5", 1'b1, 6'b000000);
    check("R5", 1'b0, 6'b000000);

    // boundary table, full mode (R1 R2 R3 R4 R6)
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][21:6], 1'b0);
      check("R1/R2/R3/R4/R6", 1'b1, VEC[i][5:0]);
      apply(VEC[i][21:6], 1'b1);
      check("R5", 1'b1, 6'b000000);
    end

    // partial-mode aliases
    apply(16'h5E00, 1'b0); check("R8",  1'b0, 6'b001000);
    apply(16'h9FFC, 1'b0); check("R9",  1'b0, 6'b010000);
    apply(16'h8000, 1'b0); check("R9",  1'b0, 6'b010000);
    apply(16'hE000, 1'b0); check("R10", 1'b0, 6'b000010);
    apply(16'hF123, 1'b0); check("R10", 1'b0, 6'b000100);
    apply(16'h6000, 1'b0); check("R11", 1'b0, 6'b100000);
    apply(16'hA000, 1'b0); check("R11", 1'b0, 6'b100000);
    apply(16'h1FFF, 1'b0); check("R1",  1'b0, 6'b000001);

    // exhaustive sweep, both modes (R7 plus full model match)
    for (int a = 0; a < 65536; a++) begin
      apply(16'(a), 1'b0);
      check("R7", 1'b1, model(16'(a), 1'b0, 1'b1));
      check("R7", 1'b0, model(16'(a), 1'b0, 1'b0));
      if ($countones(got(1'b1)) > 1 || $countones(got(1'b0)) > 1) begin
        n_cmp++; n_bad++;
        $display("FAIL R7 addr=%h got full=%b partial=%b exp at most one", addr, got(1'b1), got(1'b0));
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule